// File: doc/BRIEF.md
# Debug Command Supervisor

This controller sits in the core clock domain between a slow, asynchronous debug port and an 8-bit core. The debugger places a 3-bit command code on `dbg_cmd`. The supervisor synchronises that code and admits it only once it has been seen unchanged on consecutive reads. It then moves the core through its operations:

- reset
- free run
- single step
- skip
- debug-word injection
- instruction-memory write

It drives a core reset, a core run enable, and inhibits for register writeback and PC update. It also selects the debug word as the instruction source and strobes the instruction-memory write.

The debugger must put a NOP between any two commands. One-shot commands move the machine into a "done" twin state, where it waits for the NOP, so a command held for many cycles still acts once. A pin sampled during reset picks one of two startups. In one, the supervisor waits for the debugger. In the other, it runs a code-load pass over the whole instruction memory and then lets the core run. Halt and fault reports from the instruction scheduler stop, freeze or reboot the core. The state code is always visible on `sup_state` for readback.

Top module: `dbg_supervisor`

## Requirements
- R1: A command takes effect only after it has been present on `dbg_cmd` for two consecutive sampled clock edges. A value present at only one edge is ignored. The state changes on the fourth rising edge after the first edge that saw the new value.
- R2: The command codes are NOP=0, RESET=1, START=2, STEP=3, SKIP=4, STOP=5, INJECT=6, IMEM_WRITE=7.
- R3: A change from one non-NOP command directly to another non-NOP command is ignored. A new command acts only after NOP has been admitted in between.
- R4: STEP from IDLE (1) asserts `core_run` for exactly one cycle in state STEP (5). The machine then sits in STEP_DONE (6), whatever the command, until NOP is admitted, and then returns to IDLE.
- R5: SKIP from IDLE asserts `core_run` with `wb_block` for one cycle in state SKIP (7). It then waits in SKIP_DONE (8) for NOP.
- R6: INJECT from IDLE spends one cycle in INJECT (9). That cycle has `core_run`, `ir_from_dbg`, `wb_block` and `pc_block` all high. The machine then waits in INJECT_DONE (10) for NOP.
- R7: IMEM_WRITE from IDLE spends one cycle in IMEM_WRITE (11). That cycle has `imem_wr`, `ir_from_dbg`, `wb_block` and `pc_block` high and `core_run` low. The machine then waits in IMEM_WRITE_DONE (12) for NOP.
- R8: START from IDLE enters RUN (4), where only `core_run` is high. In RUN, STOP returns to IDLE. In RUN, START, STEP, SKIP, INJECT and IMEM_WRITE are ignored.
- R9: RESET from any state enters RESET (0), which asserts `core_rst` and nothing else. RESET is left one cycle after NOP is admitted. The destination is IDLE, or BOOT (2) if the startup pin was high during reset. Hardware reset also enters RESET.
- R10: With `boot_standalone` high during reset, the machine enters BOOT for one cycle (`core_rst`). It then enters LOAD (3) for LOAD_LEN cycles with `core_run`, `wb_block` and `imem_wr` high, and then enters RUN.
- R11: In RUN, `sch_halt` returns the machine to IDLE. In RUN or STEP, `sch_fault` enters FROZEN (13), or BOOT when FREEZE_ON_FAULT is 0. A fault takes priority over a halt. Only RESET leaves FROZEN.
- R12: `sup_state` always shows the current state code, as listed in R4 to R11. All control outputs are low in IDLE, RUN-free done states and FROZEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | asynchronous active-low reset |
| boot_standalone | input | 1 | startup selection, sampled while reset is low |
| dbg_cmd | input | 3 | command code from the asynchronous debug port |
| sch_halt | input | 1 | halt report from the instruction scheduler |
| sch_fault | input | 1 | invalid-instruction or overlay-request report |
| core_rst | output | 1 | holds the core in reset |
| core_run | output | 1 | lets the core advance one cycle |
| wb_block | output | 1 | inhibits register writeback |
| pc_block | output | 1 | inhibits PC update |
| ir_from_dbg | output | 1 | instruction register takes the debug word |
| imem_wr | output | 1 | instruction-memory write strobe |
| sup_state | output | 4 | current state code for readback |

## Verification
On every cycle, the embedded properties check several rules:
- The admitted command only ever moves through NOP.
- The filtered code changes only to a value read twice.
- Single-step lasts one cycle.
- Done and frozen states leave only along legal arcs.
- An injected word always masks writeback and PC.

The exact four-edge admission latency, the rejection of a one-edge glitch, and the ignoring of commands while running can only be shown by the bench's scenarios. The same holds for the load-pass length, the reset destination chosen by the startup pin, and the halt and fault reactions. There, a behavioural model is compared against the ports on every clock.

// File: rtl/dbgsup_pkg.sv
package dbgsup_pkg;

   typedef enum logic [2:0] {
      CMD_NOP    = 3'd0,
      CMD_RESET  = 3'd1,
      CMD_START  = 3'd2,
      CMD_STEP   = 3'd3,
      CMD_SKIP   = 3'd4,
      CMD_STOP   = 3'd5,
      CMD_INJECT = 3'd6,
      CMD_IMWR   = 3'd7
   } dbg_cmd_e;

   typedef enum logic [3:0] {
      ST_RESET     = 4'd0,
      ST_IDLE      = 4'd1,
      ST_BOOT      = 4'd2,
      ST_LOAD      = 4'd3,
      ST_RUN       = 4'd4,
      ST_STEP      = 4'd5,
      ST_STEP_DONE = 4'd6,
      ST_SKIP      = 4'd7,
      ST_SKIP_DONE = 4'd8,
      ST_INJ       = 4'd9,
      ST_INJ_DONE  = 4'd10,
      ST_IMWR      = 4'd11,
      ST_IMWR_DONE = 4'd12,
      ST_FROZEN    = 4'd13
   } sup_state_e;

   typedef struct packed {
      logic core_rst;
      logic core_run;
      logic wb_block;
      logic pc_block;
      logic ir_from_dbg;
      logic imem_wr;
   } sup_ctl_t;

endpackage

// File: rtl/dbgsup_sync.sv
module dbgsup_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2,
   parameter int AGREE  = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] q_out
);
   localparam int RW = $clog2(AGREE + 1);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dbgsup_sync: STAGES must be at least 2");
      end
      if (AGREE < 2) begin : g_bad_agree
         $error("dbgsup_sync: AGREE must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stg;
   logic [W-1:0]             sync_v;
   logic [W-1:0]             hold;
   logic [RW-1:0]            run;

   assign sync_v = stg[STAGES-1];

   // metastability chain
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d_in};
   end

   // agreement filter: accept a value once AGREE consecutive reads match
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold  <= '0;
         run   <= RW'(1);
         q_out <= '0;
      end else begin
         hold <= sync_v;
         if (sync_v != hold)         run <= RW'(1);
         else if (int'(run) < AGREE) run <= run + RW'(1);
         if (sync_v == hold && int'(run) + 1 >= AGREE) q_out <= sync_v;
      end
   end

   // R1: the filtered code only moves to a value read on two successive edges
   a_r1_two_reads: assert property (@(posedge clk) disable iff (!rst_n)
      (q_out != $past(q_out)) |-> (q_out == $past(sync_v) && q_out == $past(sync_v, 2)));

endmodule

// File: rtl/dbgsup_fsm.sv
module dbgsup_fsm
   import dbgsup_pkg::*;
#(
   parameter int LOAD_LEN        = 256,
   parameter bit FREEZE_ON_FAULT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       boot_pin,
   input  dbg_cmd_e   cmd,
   input  logic       sch_halt,
   input  logic       sch_fault,
   output sup_state_e state_o
);
   localparam int LW = (LOAD_LEN > 2) ? $clog2(LOAD_LEN) : 1;

   generate
      if (LOAD_LEN < 2) begin : g_bad_len
         $error("dbgsup_fsm: LOAD_LEN must be at least 2");
      end
   endgenerate

   sup_state_e fault_dest;
   generate
      if (FREEZE_ON_FAULT) begin : g_freeze
         assign fault_dest = ST_FROZEN;
      end else begin : g_reboot
         assign fault_dest = ST_BOOT;
      end
   endgenerate

   sup_state_e state, nxt;
   dbg_cmd_e   acc, acc_nxt;
   logic       mode_q;
   logic [LW-1:0] ld_cnt;
   logic       legal, fire, back, ld_last;

   assign state_o = state;
   assign legal   = (cmd != acc) && (acc == CMD_NOP || cmd == CMD_NOP);
   assign fire    = legal && (cmd != CMD_NOP);
   assign back    = legal && (cmd == CMD_NOP);
   assign acc_nxt = legal ? cmd : acc;
   assign ld_last = (ld_cnt == LW'(LOAD_LEN - 1));

   always_comb begin
      nxt = state;
      unique case (state)
         ST_RESET:     if (acc == CMD_NOP) nxt = mode_q ? ST_BOOT : ST_IDLE;
         ST_IDLE: begin
            if (fire) begin
               unique case (cmd)
                  CMD_START:  nxt = ST_RUN;
                  CMD_STEP:   nxt = ST_STEP;
                  CMD_SKIP:   nxt = ST_SKIP;
                  CMD_INJECT: nxt = ST_INJ;
                  CMD_IMWR:   nxt = ST_IMWR;
                  default:    nxt = ST_IDLE;
               endcase
            end
         end
         ST_BOOT:      nxt = ST_LOAD;
         ST_LOAD:      if (ld_last) nxt = ST_RUN;
         ST_RUN: begin
            if (sch_fault)                    nxt = fault_dest;
            else if (sch_halt)                nxt = ST_IDLE;
            else if (fire && cmd == CMD_STOP) nxt = ST_IDLE;
         end
         ST_STEP:      nxt = sch_fault ? fault_dest : ST_STEP_DONE;
         ST_SKIP:      nxt = ST_SKIP_DONE;
         ST_INJ:       nxt = ST_INJ_DONE;
         ST_IMWR:      nxt = ST_IMWR_DONE;
         ST_STEP_DONE,
         ST_SKIP_DONE,
         ST_INJ_DONE,
         ST_IMWR_DONE: if (back) nxt = ST_IDLE;
         ST_FROZEN:    nxt = ST_FROZEN;
         default:      nxt = ST_RESET;
      endcase
      if (fire && cmd == CMD_RESET) nxt = ST_RESET;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_RESET;
         acc    <= CMD_NOP;
         ld_cnt <= '0;
      end else begin
         state  <= nxt;
         acc    <= acc_nxt;
         ld_cnt <= (state == ST_LOAD) ? ld_cnt + LW'(1) : '0;
      end
   end

   // startup selection captured on clock edges while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= boot_pin;
   end

   // R3: the admitted command never jumps between two non-NOP codes
   a_r3_nop_between: assert property (@(posedge clk) disable iff (!rst_n)
      (acc != $past(acc)) |-> (acc == CMD_NOP || $past(acc) == CMD_NOP));
   // R4: single step lasts exactly one cycle
   a_r4_step_single: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STEP) |=> (state != ST_STEP));
   // R4: the done twin only exits to idle or reset
   a_r4_done_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STEP_DONE) |=> (state inside {ST_STEP_DONE, ST_IDLE, ST_RESET}));
   // R11: frozen is left only through reset
   a_r11_frozen_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FROZEN) |=> (state inside {ST_FROZEN, ST_RESET}));
   // R10: the load pass is always preceded by the boot cycle
   a_r10_load_after_boot: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state == ST_LOAD) |-> ($past(state) == ST_BOOT));
   // R8: run is entered only from idle or from the end of a load pass
   a_r8_run_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && $past(state) != ST_RUN) |-> ($past(state) inside {ST_IDLE, ST_LOAD}));

endmodule

// File: rtl/dbgsup_outdec.sv
module dbgsup_outdec
   import dbgsup_pkg::*;
(
   input  sup_state_e state,
   output sup_ctl_t   ctl
);
   always_comb begin
      ctl = '0;
      unique case (state)
         ST_RESET, ST_BOOT: ctl.core_rst = 1'b1;
         ST_LOAD: begin
            ctl.core_run = 1'b1;
            ctl.wb_block = 1'b1;
            ctl.imem_wr  = 1'b1;
         end
         ST_RUN, ST_STEP: ctl.core_run = 1'b1;
         ST_SKIP: begin
            ctl.core_run = 1'b1;
            ctl.wb_block = 1'b1;
         end
         ST_INJ: begin
            ctl.core_run    = 1'b1;
            ctl.wb_block    = 1'b1;
            ctl.pc_block    = 1'b1;
            ctl.ir_from_dbg = 1'b1;
         end
         ST_IMWR: begin
            ctl.imem_wr     = 1'b1;
            ctl.wb_block    = 1'b1;
            ctl.pc_block    = 1'b1;
            ctl.ir_from_dbg = 1'b1;
         end
         default: ctl = '0;
      endcase
   end
endmodule

// File: rtl/dbg_supervisor.sv
module dbg_supervisor #(
   parameter int SYNC_STAGES     = 2,
   parameter int AGREE_READS     = 2,
   parameter int LOAD_LEN        = 256,
   parameter bit FREEZE_ON_FAULT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       boot_standalone,
   input  logic [2:0] dbg_cmd,
   input  logic       sch_halt,
   input  logic       sch_fault,
   output logic       core_rst,
   output logic       core_run,
   output logic       wb_block,
   output logic       pc_block,
   output logic       ir_from_dbg,
   output logic       imem_wr,
   output logic [3:0] sup_state
);
   import dbgsup_pkg::*;

   localparam int CMD_W = $bits(dbg_cmd_e);

   logic [CMD_W-1:0] cmd_f;
   sup_state_e       st;
   sup_ctl_t         ctl;

   dbgsup_sync #(.W(CMD_W), .STAGES(SYNC_STAGES), .AGREE(AGREE_READS)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (dbg_cmd),
      .q_out (cmd_f)
   );

   dbgsup_fsm #(.LOAD_LEN(LOAD_LEN), .FREEZE_ON_FAULT(FREEZE_ON_FAULT)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .boot_pin  (boot_standalone),
      .cmd       (dbg_cmd_e'(cmd_f)),
      .sch_halt  (sch_halt),
      .sch_fault (sch_fault),
      .state_o   (st)
   );

   dbgsup_outdec u_dec (
      .state (st),
      .ctl   (ctl)
   );

   assign core_rst    = ctl.core_rst;
   assign core_run    = ctl.core_run;
   assign wb_block    = ctl.wb_block;
   assign pc_block    = ctl.pc_block;
   assign ir_from_dbg = ctl.ir_from_dbg;
   assign imem_wr     = ctl.imem_wr;
   assign sup_state   = st;

   // R6: an injected word never updates registers or PC
   a_r6_inject_masks: assert property (@(posedge clk) disable iff (!rst_n)
      ir_from_dbg |-> (wb_block && pc_block));
   // R9: a core held in reset is never advanced
   a_r9_rst_no_run: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst |-> !core_run);
   // R7: memory is never written while the core is in reset
   a_r7_write_not_rst: assert property (@(posedge clk) disable iff (!rst_n)
      imem_wr |-> (!core_rst && wb_block));

endmodule

// File: tb/dbg_supervisor_test.sv
module dbg_supervisor_test;
   localparam int LOAD_LEN = 256;
   localparam int STAGES   = 2;
   localparam int AGREE    = 2;

   localparam int C_NOP = 0, C_RESET = 1, C_START = 2, C_STEP = 3,
                  C_SKIP = 4, C_STOP = 5, C_INJ = 6, C_IMWR = 7;
   localparam int S_RESET = 0, S_IDLE = 1, S_BOOT = 2, S_LOAD = 3, S_RUN = 4,
                  S_STEP = 5, S_STEP_D = 6, S_SKIP = 7, S_SKIP_D = 8,
                  S_INJ = 9, S_INJ_D = 10, S_IMWR = 11, S_IMWR_D = 12, S_FROZEN = 13;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       boot_standalone = 1'b1;
   logic [2:0] dbg_cmd = 3'd0;
   logic       sch_halt = 1'b0;
   logic       sch_fault = 1'b0;
   logic       core_rst, core_run, wb_block, pc_block, ir_from_dbg, imem_wr;
   logic [3:0] sup_state;

   int vectors = 0;
   int fails   = 0;
   int cyc     = 0;

   dbg_supervisor uut (
      .clk(clk), .rst_n(rst_n), .boot_standalone(boot_standalone),
      .dbg_cmd(dbg_cmd), .sch_halt(sch_halt), .sch_fault(sch_fault),
      .core_rst(core_rst), .core_run(core_run), .wb_block(wb_block),
      .pc_block(pc_block), .ir_from_dbg(ir_from_dbg), .imem_wr(imem_wr),
      .sup_state(sup_state)
   );

   always #10 clk = ~clk;

   // behavioural reference: command history, admitted command, state
   int m_state = S_RESET;
   int m_acc   = C_NOP;
   int m_filt  = C_NOP;
   int m_cnt   = 0;
   int m_mode  = 0;
   int hist[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = S_RESET; m_acc = C_NOP; m_filt = C_NOP; m_cnt = 0;
         m_mode  = int'(boot_standalone);
         hist = '{0, 0, 0, 0, 0, 0};
      end else begin
         bit legal, fire, back, ok;
         int ns;
         legal = (m_filt != m_acc) && (m_acc == C_NOP || m_filt == C_NOP);
         fire  = legal && m_filt != C_NOP;
         back  = legal && m_filt == C_NOP;
         ns = m_state;
         case (m_state)
            S_RESET: if (m_acc == C_NOP) ns = m_mode ? S_BOOT : S_IDLE;
            S_IDLE: if (fire) begin
               if (m_filt == C_START) ns = S_RUN;
               else if (m_filt == C_STEP) ns = S_STEP;
               else if (m_filt == C_SKIP) ns = S_SKIP;
               else if (m_filt == C_INJ)  ns = S_INJ;
               else if (m_filt == C_IMWR) ns = S_IMWR;
            end
            S_BOOT: ns = S_LOAD;
            S_LOAD: if (m_cnt == LOAD_LEN - 1) ns = S_RUN;
            S_RUN: begin
               if (sch_fault) ns = S_FROZEN;
               else if (sch_halt) ns = S_IDLE;
               else if (fire && m_filt == C_STOP) ns = S_IDLE;
            end
            S_STEP: ns = sch_fault ? S_FROZEN : S_STEP_D;
            S_SKIP: ns = S_SKIP_D;
            S_INJ:  ns = S_INJ_D;
            S_IMWR: ns = S_IMWR_D;
            S_STEP_D, S_SKIP_D, S_INJ_D, S_IMWR_D: if (back) ns = S_IDLE;
            default: ns = m_state;
         endcase
         if (fire && m_filt == C_RESET) ns = S_RESET;
         m_cnt = (m_state == S_LOAD) ? m_cnt + 1 : 0;
         if (legal) m_acc = m_filt;
         m_state = ns;
         ok = 1'b1;
         for (int j = 0; j < AGREE; j++)
            if (hist[hist.size() - STAGES - j] != hist[hist.size() - STAGES]) ok = 1'b0;
         if (ok) m_filt = hist[hist.size() - STAGES];
         hist.push_back(int'(dbg_cmd));
         if (hist.size() > 16) void'(hist.pop_front());
      end
   end

   // expected control pattern {rst, run, wb, pc, ird, imw}
   function automatic logic [5:0] exp_out(int s);
      case (s)
         S_RESET, S_BOOT: return 6'b100000;
         S_LOAD:          return 6'b011001;
         S_RUN, S_STEP:   return 6'b010000;
         S_SKIP:          return 6'b011000;
         S_INJ:           return 6'b011110;
         S_IMWR:          return 6'b001111;
         default:         return 6'b000000;
      endcase
   endfunction

   function automatic string req_of(int s);
      case (s)
         S_RESET:             return "R9";
         S_BOOT, S_LOAD:      return "R10";
         S_RUN:               return "R8";
         S_STEP, S_STEP_D:    return "R4";
         S_SKIP, S_SKIP_D:    return "R5";
         S_INJ, S_INJ_D:      return "R6";
         S_IMWR, S_IMWR_D:    return "R7";
         S_FROZEN:            return "R11";
         default:             return "R12";
      endcase
   endfunction

   // per-clock comparison against the model
   always @(negedge clk) begin
      logic [5:0] act;
      act = {core_rst, core_run, wb_block, pc_block, ir_from_dbg, imem_wr};
      vectors++;
      if (sup_state !== 4'(m_state) || act !== exp_out(m_state)) begin
         fails++;
         $display("FAIL %s t=%0t actual state=%0d ctl=%b expected state=%0d ctl=%b",
                  req_of(m_state), $time, sup_state, act, m_state, exp_out(m_state));
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         fails++;
         $display("FAIL watchdog (R1..all) actual=hung expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   task automatic hold_cmd(input int c, input int n);
      @(negedge clk); #1;
      dbg_cmd = 3'(c);
      repeat (n) @(posedge clk);
   endtask

   task automatic pulse(input bit fault);
      @(negedge clk); #1;
      if (fault) sch_fault = 1'b1; else sch_halt = 1'b1;
      @(negedge clk); #1;
      sch_fault = 1'b0; sch_halt = 1'b0;
   endtask

   task automatic chk(input int exp, input string tag);
      @(negedge clk);
      vectors++;
      if (sup_state !== 4'(exp)) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, sup_state, exp);
      end
   endtask

   initial begin
      // R10: standalone start, boot, load pass, then run
      repeat (3) @(posedge clk);
      chk(S_RESET, "R9 hardware reset state");
      @(negedge clk); #1 rst_n = 1'b1;
      chk(S_BOOT, "R10 boot cycle");
      chk(S_LOAD, "R10 load pass");
      repeat (LOAD_LEN + 4) @(posedge clk);
      chk(S_RUN, "R10 run after load");
      // R11: halt while running
      pulse(1'b0);
      chk(S_IDLE, "R11 halt to idle");
      // R9: hardware reset with debugger startup
      @(negedge clk); #1 rst_n = 1'b0; boot_standalone = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk); #1 rst_n = 1'b1;
      repeat (2) @(posedge clk);
      chk(S_IDLE, "R9 debugger startup to idle");
      // R4 step, R2 code 3
      hold_cmd(C_STEP, 8);  chk(S_STEP_D, "R4 step done held");
      hold_cmd(C_NOP, 8);   chk(S_IDLE, "R4 back to idle");
      hold_cmd(C_SKIP, 8);  chk(S_SKIP_D, "R5 skip done");
      hold_cmd(C_NOP, 8);   chk(S_IDLE, "R5 back to idle");
      hold_cmd(C_INJ, 8);   chk(S_INJ_D, "R6 inject done");
      hold_cmd(C_NOP, 8);   chk(S_IDLE, "R6 back to idle");
      hold_cmd(C_IMWR, 8);  chk(S_IMWR_D, "R7 write done");
      hold_cmd(C_NOP, 8);   chk(S_IDLE, "R7 back to idle");
      // R1: one-edge glitch ignored
      hold_cmd(C_STEP, 1);
      hold_cmd(C_NOP, 8);   chk(S_IDLE, "R1 glitch ignored");
      // R3: direct change between commands ignored
      hold_cmd(C_STEP, 8);  chk(S_STEP_D, "R3 step accepted");
      hold_cmd(C_SKIP, 8);  chk(S_STEP_D, "R3 skip without nop ignored");
      hold_cmd(C_NOP, 8);   chk(S_IDLE, "R3 nop releases");
      // R8: run, ignored inject, stop
      hold_cmd(C_START, 8); chk(S_RUN, "R8 start");
      hold_cmd(C_NOP, 8);
      hold_cmd(C_INJ, 8);   chk(S_RUN, "R8 inject ignored in run");
      hold_cmd(C_NOP, 8);
      hold_cmd(C_STOP, 8);  chk(S_IDLE, "R8 stop");
      hold_cmd(C_NOP, 8);
      // R9: reset command from run
      hold_cmd(C_START, 8);
      hold_cmd(C_NOP, 8);
      hold_cmd(C_RESET, 8); chk(S_RESET, "R9 reset command");
      hold_cmd(C_NOP, 8);   chk(S_IDLE, "R9 reset exit to idle");
      // R11: fault freezes, only reset leaves
      hold_cmd(C_START, 8);
      hold_cmd(C_NOP, 8);
      pulse(1'b1);
      chk(S_FROZEN, "R11 fault freezes");
      hold_cmd(C_START, 8); chk(S_FROZEN, "R11 start ignored when frozen");
      hold_cmd(C_NOP, 8);
      hold_cmd(C_RESET, 8); chk(S_RESET, "R11 reset leaves frozen");
      hold_cmd(C_NOP, 8);   chk(S_IDLE, "R12 idle code");
      repeat (4) @(posedge clk);
      @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule